// File: doc/BRIEF.md
# Six-Output Edge-Programmable PWM Generator

This block drives six pulse-width-modulated outputs from one shared up-counter that advances on every clock. Seven compare values are kept: compare 0 fixes the period (the counter returns to zero on the cycle after it equals compare 0), and compares 1 to 6 place the edges of the outputs. Output k+1 appears on `pwm_o[k]`. Each output runs in one of two modes. In single-edge mode it goes high at the start of every period and low at its own compare value. In double-edge mode, available to outputs 2 to 6, it goes high when the count reaches the compare below its own and low when the count reaches its own compare. With this mode, several outputs can carry pulses that do not overlap and that sit anywhere inside the period.

Compare values and mode bits are written through a simple write port into holding registers. Every period begins with one commit point. At that point the held values are copied into the working set, so a period never mixes old and new settings. The timebase is a two-state machine. `ST_IDLE` holds the count at zero and the outputs low. Transition START (run high) moves it to `ST_RUN` and commits the held values. In `ST_RUN`, transition WRAP (count equals compare 0) restarts the count and commits again. Transition HALT (run low) returns it to `ST_IDLE`.

Top module: `pwm_multi_edge`

## Requirements
- R1: While `run` stays high, `count_o` counts 0, 1, … up to the working compare 0 value and then shows 0 on the next cycle, so the period is compare 0 plus one cycles.
- R2: `cycle_start_o` is high exactly in the running cycles in which `count_o` is 0.
- R3: In single-edge mode with working compare n satisfying 0 < n < compare 0, `pwm_o[n-1]` is high in the cycles whose count is below compare n and low otherwise.
- R4: In single-edge mode a compare n of 0 keeps `pwm_o[n-1]` low. A nonzero compare n greater than or equal to compare 0 keeps it high.
- R5: Mode bit k of `mode_wdata` set to 1 selects double-edge mode for `pwm_o[k]` (k from 1 to 5). The output becomes high in the cycle whose count equals compare k, becomes low in the cycle whose count equals compare k+1, and otherwise keeps its level.
- R6: In double-edge mode, when the rising and falling compares match in the same cycle, the output is low in that cycle.
- R7: A write to compare `mr_sel` (0 to 6) or to the mode bits is held. It takes effect from the next cycle in which `count_o` returns to 0. A write made in the cycle where `count_o` equals compare 0 takes effect one period later. Starting from idle commits the held values.
- R8: Writes with `mr_sel` of 7 change no compare value.
- R9: Bit 0 of `mode_wdata` is ignored, and `pwm_o[0]` always behaves in single-edge mode.
- R10: After reset, `count_o` is 0, `pwm_o` and `cycle_start_o` are low, and all held compare values and mode bits are 0.
- R11: A cycle with `run` low is followed by a cycle with `count_o` 0 and all outputs low. The next start counts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low returns the block to idle |
| mr_we | input | 1 | Write strobe for a held compare value |
| mr_sel | input | 3 | Compare index 0 to 6; 7 is ignored |
| mr_wdata | input | CW (8) | Compare value to hold |
| mode_we | input | 1 | Write strobe for the held mode bits |
| mode_wdata | input | NCH (6) | Mode per output, 1 = double edge; bit 0 ignored |
| pwm_o | output | NCH (6) | PWM outputs, bit k is output k+1 |
| count_o | output | CW (8) | Current counter value |
| cycle_start_o | output | 1 | High in the first cycle of each running period |

## Verification
Two events can coincide. In one, a double-edge output has its rising and falling compares set to the same value. In the other, a compare write arrives on the very edge that commits the held values. The directed part sets two compares equal and checks that the output stays low at that count. It also issues a write in the cycle where the count equals compare 0 and checks that the old value still governs the following period and the new one the period after. The random part keeps a bench model of the held and working sets. Because writes, mode changes and halts are drawn freely, both collisions recur many times, and every cycle's counter, period marker and outputs are compared against that model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period_a,
    output pwm_state_e    state_q,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          load,
    output logic          cyc_start
);
    pwm_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: START, WRAP, HALT
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == period_a) begin
                    load = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cyc_start = (state_q == ST_RUN) && (cnt_q == '0);
    end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int CW  = 8,
    parameter int NCH = 6,
    localparam int NMR = NCH + 1,
    localparam int SW  = $clog2(NMR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SW-1:0]     sel,
    input  logic [CW-1:0]     wdata,
    input  logic              mode_we,
    input  logic [NCH-1:0]    mode_wdata,
    input  logic              load,
    output logic [NMR*CW-1:0] act_q,
    output logic [NMR*CW-1:0] act_d,
    output logic [NCH-1:0]    mode_q,
    output logic [NCH-1:0]    mode_d
);
    localparam logic [NCH-1:0] DMASK = {{(NCH-1){1'b1}}, 1'b0};

    for (genvar g = 0; g < NMR; g++) begin : g_reg
        logic [CW-1:0] hold_r;
        logic [CW-1:0] work_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_r <= '0;
                work_r <= '0;
            end else begin
                if (load) work_r <= hold_r;
                if (we && (sel == SW'(g))) hold_r <= wdata;
            end
        end
        assign act_q[g*CW +: CW] = work_r;
        assign act_d[g*CW +: CW] = load ? hold_r : work_r;
    end

    logic [NCH-1:0] mode_hold;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_hold <= '0;
            mode_q    <= '0;
        end else begin
            if (load) mode_q <= mode_hold;
            if (mode_we) mode_hold <= mode_wdata & DMASK;
        end
    end
    assign mode_d = load ? mode_hold : mode_q;
endmodule

// File: rtl/pwm_edge_ch.sv
module pwm_edge_ch #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_d,
    input  logic [CW-1:0] cnt_d,
    input  logic [CW-1:0] per_d,
    input  logic [CW-1:0] own_d,
    input  logic [CW-1:0] prv_d,
    input  logic          dbl_d,
    output logic          q
);
    logic set_ev, clr_ev, q_d;

    always_comb begin
        if (dbl_d) begin
            set_ev = (cnt_d == prv_d);
            clr_ev = (cnt_d == own_d);
        end else begin
            set_ev = (cnt_d == '0);
            clr_ev = (cnt_d == own_d) && ((own_d == '0) || (own_d < per_d));
        end
        if (!run_d)      q_d = 1'b0;
        else if (clr_ev) q_d = 1'b0;
        else if (set_ev) q_d = 1'b1;
        else             q_d = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_d;
    end
endmodule

// File: rtl/pwm_multi_edge.sv
module pwm_multi_edge
    import pwm_pkg::*;
#(
    parameter int CW  = 8,
    parameter int NCH = 6,
    localparam int NMR = NCH + 1,
    localparam int SW  = $clog2(NMR)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           mr_we,
    input  logic [SW-1:0]  mr_sel,
    input  logic [CW-1:0]  mr_wdata,
    input  logic           mode_we,
    input  logic [NCH-1:0] mode_wdata,
    output logic [NCH-1:0] pwm_o,
    output logic [CW-1:0]  count_o,
    output logic           cycle_start_o
);
    pwm_state_e         state_q;
    logic [CW-1:0]      cnt_d;
    logic               load;
    logic               running;
    logic [NMR*CW-1:0]  mr_act;
    logic [NMR*CW-1:0]  mr_nxt;
    logic [NCH-1:0]     mode_act;
    logic [NCH-1:0]     mode_nxt;

    pwm_timebase #(.CW(CW)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .period_a  (mr_act[CW-1:0]),
        .state_q   (state_q),
        .cnt_q     (count_o),
        .cnt_d     (cnt_d),
        .load      (load),
        .cyc_start (cycle_start_o)
    );

    assign running = (state_q == ST_RUN);

    pwm_match_bank #(.CW(CW), .NCH(NCH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (mr_we),
        .sel        (mr_sel),
        .wdata      (mr_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .load       (load),
        .act_q      (mr_act),
        .act_d      (mr_nxt),
        .mode_q     (mode_act),
        .mode_d     (mode_nxt)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        pwm_edge_ch #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .run_d (run),
            .cnt_d (cnt_d),
            .per_d (mr_nxt[CW-1:0]),
            .own_d (mr_nxt[(k+1)*CW +: CW]),
            .prv_d (mr_nxt[k*CW +: CW]),
            .dbl_d (mode_nxt[k]),
            .q     (pwm_o[k])
        );
    end
endmodule

// File: rtl/pwm_multi_edge_chk.sv
module pwm_multi_edge_chk #(
    parameter int CW  = 8,
    parameter int NCH = 6,
    localparam int NMR = NCH + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CW-1:0]     count_o,
    input logic              cycle_start_o,
    input logic [NCH-1:0]    pwm_o,
    input logic              running,
    input logic [NMR*CW-1:0] mr_act,
    input logic [NCH-1:0]    mode_act
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run && count_o != mr_act[CW-1:0]) |=> count_o == $past(count_o) + CW'(1));

    assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> (count_o == '0));

    assert_halt_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_o == '0) && (pwm_o == '0) && !cycle_start_o);

    assert_commit_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != '0) |-> ($stable(mr_act) && $stable(mode_act)));

    for (genvar k = 0; k < NCH; k++) begin : g_low
        assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (running && !mode_act[k] && mr_act[(k+1)*CW +: CW] == '0) |-> !pwm_o[k]);
    end
endmodule

bind pwm_multi_edge pwm_multi_edge_chk #(.CW(CW), .NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .count_o       (count_o),
    .cycle_start_o (cycle_start_o),
    .pwm_o         (pwm_o),
    .running       (running),
    .mr_act        (mr_act),
    .mode_act      (mode_act)
);

// File: tb/tb_pwm_multi_edge.sv
module tb_pwm_multi_edge;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run, mr_we, mode_we;
    logic [2:0] mr_sel;
    logic [7:0] mr_wdata;
    logic [5:0] mode_wdata;
    logic [5:0] pwm_o;
    logic [7:0] count_o;
    logic       cycle_start_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] m_sh [7];
    logic [7:0] m_act[7];
    logic [5:0] m_msh, m_mact, m_q;
    logic [7:0] m_tc;
    logic       m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_multi_edge dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mr_we(mr_we), .mr_sel(mr_sel),
        .mr_wdata(mr_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .pwm_o(pwm_o), .count_o(count_o), .cycle_start_o(cycle_start_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 7; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        m_msh = '0; m_mact = '0; m_q = '0; m_tc = '0; m_run = 1'b0;
    endtask

    // next-cycle expectation from the requirements
    task automatic model_step(input logic r, we, input logic [2:0] s, input logic [7:0] d,
                              input logic mwe, input logic [5:0] md);
        logic ld;
        logic [7:0] tcn, own, prv, per;
        logic st, cl;
        ld  = r && (!m_run || (m_tc == m_act[0]));
        tcn = (!r || ld) ? 8'd0 : m_tc + 8'd1;
        if (ld) begin
            for (int i = 0; i < 7; i++) m_act[i] = m_sh[i];
            m_mact = m_msh;
        end
        per = m_act[0];
        for (int k = 0; k < 6; k++) begin
            own = m_act[k+1];
            prv = m_act[k];
            if (m_mact[k]) begin
                st = (tcn == prv); cl = (tcn == own);
            end else begin
                st = (tcn == 0); cl = (tcn == own) && (own == 0 || own < per);
            end
            if (!r || cl) m_q[k] = 1'b0;
            else if (st)  m_q[k] = 1'b1;
        end
        if (we && s <= 3'd6) m_sh[s] = d;
        if (mwe) m_msh = md & 6'b111110;
        m_run = r;
        m_tc  = tcn;
    endtask

    task automatic compare();
        chk(count_o == m_tc, "R1 count", count_o, m_tc);
        chk(cycle_start_o == (m_run && m_tc == 0), "R2 cycle_start", cycle_start_o,
            int'(m_run && m_tc == 0));
        for (int k = 0; k < 6; k++)
            chk(pwm_o[k] == m_q[k], m_mact[k] ? "R5 double-edge output" : "R3 single-edge output",
                pwm_o[k], m_q[k]);
    endtask

    task automatic tick(input logic r, we, input logic [2:0] s, input logic [7:0] d,
                        input logic mwe, input logic [5:0] md);
        run = r; mr_we = we; mr_sel = s; mr_wdata = d; mode_we = mwe; mode_wdata = md;
        model_step(r, we, s, d, mwe, md);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_tick(input logic r);
        tick(r, 1'b0, 3'd0, 8'd0, 1'b0, 6'd0);
    endtask

    task automatic run_to(input logic [7:0] target);
        for (int i = 0; i < 40; i++) begin
            idle_tick(1'b1);
            if (count_o == target) return;
        end
        chk(1'b0, "R1 count target", count_o, target);
    endtask

    initial begin
        logic r, we, mwe;
        logic [2:0] s;
        logic [7:0] d;
        logic [5:0] md;
        rst_n = 1'b0; run = 0; mr_we = 0; mr_sel = 0; mr_wdata = 0; mode_we = 0; mode_wdata = 0;
        model_reset();
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(count_o == 0, "R10 count", count_o, 0);
        chk(pwm_o == 0, "R10 pwm", pwm_o, 0);
        chk(cycle_start_o == 0, "R10 cycle_start", cycle_start_o, 0);
        rst_n = 1'b1;

        // program while idle
        tick(0, 1, 3'd0, 8'd9, 0, 0);
        tick(0, 1, 3'd1, 8'd0, 0, 0);
        tick(0, 1, 3'd2, 8'd9, 0, 0);
        tick(0, 1, 3'd3, 8'd4, 0, 0);
        tick(0, 1, 3'd4, 8'd7, 0, 0);
        tick(0, 1, 3'd5, 8'd7, 0, 0);
        tick(0, 1, 3'd6, 8'd12, 1, 6'b011001);
        chk(pwm_o == 0, "R11 idle outputs", pwm_o, 0);

        for (int i = 0; i < 25; i++) begin
            idle_tick(1'b1);
            chk(pwm_o[0] == 0, "R4 zero compare low / R9 bit0 ignored", pwm_o[0], 0);
            chk(pwm_o[1] == 1, "R4 compare>=period high", pwm_o[1], 1);
            chk(pwm_o[2] == (count_o < 4), "R3 fall at compare", pwm_o[2], int'(count_o < 4));
            chk(pwm_o[3] == (count_o >= 4 && count_o < 7), "R5 placed pulse", pwm_o[3],
                int'(count_o >= 4 && count_o < 7));
            chk(pwm_o[4] == 0, "R6 clear wins", pwm_o[4], 0);
            chk(pwm_o[5] == 1, "R4 compare>period high", pwm_o[5], 1);
        end

        // R7 held write mid-period
        run_to(8'd2);
        tick(1, 1, 3'd3, 8'd2, 0, 0);
        chk(pwm_o[2] == 1, "R7 old value still active", pwm_o[2], 1);
        run_to(8'd3);
        chk(pwm_o[2] == 0, "R7 new value after boundary", pwm_o[2], 0);
        // R7 write on the boundary cycle
        run_to(8'd9);
        tick(1, 1, 3'd3, 8'd6, 0, 0);
        run_to(8'd3);
        chk(pwm_o[2] == 0, "R7 boundary write deferred", pwm_o[2], 0);
        run_to(8'd3);
        chk(pwm_o[2] == 1, "R7 boundary write applied", pwm_o[2], 1);
        // R8 invalid index
        tick(1, 1, 3'd7, 8'd0, 0, 0);
        run_to(8'd0);
        run_to(8'd9);
        chk(count_o == 9, "R8 period kept", count_o, 9);
        // R11 halt and restart
        idle_tick(1'b0);
        chk(count_o == 0 && pwm_o == 0 && !cycle_start_o, "R11 halt", count_o, 0);
        idle_tick(1'b1);
        chk(count_o == 0 && cycle_start_o, "R11 restart at zero", count_o, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            r   = ($urandom % 60) != 0;
            we  = ($urandom % 6) == 0;
            s   = 3'($urandom % 8);
            d   = (s == 0) ? 8'(2 + $urandom % 19) : 8'($urandom % 24);
            mwe = ($urandom % 25) == 0;
            md  = 6'($urandom);
            if ((i % 200) == 0) begin
                // collide a write with the boundary edge
                if (count_o == m_act[0] && m_run) we = 1'b1;
            end
            tick(r, we, s, d, mwe, md);
        end
        finish_run();
    end
endmodule